// File: doc/BRIEF.md
# Drawing Engine Parameter Queue and Launch Control

This block holds the operation parameters of a 2D drawing engine. A host writes single bytes at 8-bit offsets into a queued copy of the parameters. The parameters are the pattern, source and destination base addresses, three row steps, the X and Y counts, the pattern and source wrap selects, a routing byte and two raster-operation codes. The queued copy can be rewritten freely at any time, and the drawing engine never sees those writes directly. A readback port returns the queued bytes, so software can inspect what it has staged.

A write to the most significant byte of the destination address is the launch trigger. On that edge the byte is merged into the queue, the whole queued set is copied into the working set that drives the engine, and a one-cycle start pulse is raised. At the same moment the block decides whether the operation can run straight away or must wait for host-supplied data. It runs at once when the routing byte masked with 0x37 is zero. If the engine reports busy when the trigger arrives, the launch is held back until the first edge on which busy is low. The copy is taken then, so it includes any queued writes made in the meantime.

Top module: `blit_reg_queue`

## Requirements
- R1: After reset every queued and working field, the start pulse and the run-immediately flag are zero.
- R2: Each 32-bit address is assembled little-endian from four byte offsets: pattern at 0x80–0x83, source at 0x84–0x87, destination at 0xA0–0xA3. The lowest offset holds bits 7:0.
- R3: Row steps are 16-bit little-endian values: pattern at 0x88/0x89, source at 0x8A/0x8B, destination at 0x8C/0x8D. The X count is at 0x98/0x99 and the Y count at 0x9A/0x9B, each stored as written (a stored value n means n+1 pixels or rows).
- R4: The pattern wrap byte (0x90) and the source wrap byte (0x91) keep only the bits under mask 0x77. Bits 2:0 are the X wrap select and bits 6:4 the Y wrap select. Bits 3 and 7 always read zero.
- R5: The routing byte (0x92), the foreground raster code (0x94) and the background raster code (0x95) store all eight bits.
- R6: A queued write to any offset other than 0xA3 leaves the working set unchanged and raises no start.
- R7: A write to 0xA3 while busy is low makes the full working set, including the byte just written, visible in the cycle after the write edge. The start pulse is high in that same cycle.
- R8: Each launch raises the start pulse for exactly one cycle.
- R9: At each launch the run-immediately flag becomes 1 if the launched routing byte ANDed with 0x37 is zero, and 0 otherwise. It holds that value until the next launch.
- R10: A write to 0xA3 while busy is high launches nothing. The launch happens on the first edge with busy low and copies the queued values present at that edge.
- R11: Writes to offsets outside the map change no stored byte, and reads of such offsets return zero.
- R12: The readback data reflects the queued byte at the read offset combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrOffset | input | 8 | Byte write offset |
| wrData | input | 8 | Byte write data |
| rdOffset | input | 8 | Readback offset |
| rdData | output | 8 | Queued byte at rdOffset |
| engineBusy | input | 1 | Drawing engine busy; defers a launch |
| startPulse | output | 1 | One-cycle launch strobe |
| runNow | output | 1 | Launched operation needs no host data |
| wkPatAddr | output | 32 | Working pattern address |
| wkSrcAddr | output | 32 | Working source address |
| wkDstAddr | output | 32 | Working destination address |
| wkPatStep | output | 16 | Working pattern row step |
| wkSrcStep | output | 16 | Working source row step |
| wkDstStep | output | 16 | Working destination row step |
| wkCountX | output | 16 | Working X count |
| wkCountY | output | 16 | Working Y count |
| wkPatWrap | output | 8 | Working pattern wrap selects |
| wkSrcWrap | output | 8 | Working source wrap selects |
| wkRouting | output | 8 | Working routing byte |
| wkRopFore | output | 8 | Working foreground raster code |
| wkRopBack | output | 8 | Working background raster code |

## Verification
A queued byte lands on the edge that samples the write, and readback is combinational, so a read is checked 1 ns after its offset is applied. A launch shows its working set, start pulse and run flag in the cycle that follows the triggering edge. The start pulse is checked low again one cycle after that. A deferred launch is due one edge after busy falls. The bench drives every input on the falling clock edge and samples on the next falling edge, which puts each check exactly one rising edge after its stimulus.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int ADDR_W = 32;
  localparam int STEP_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int STEP_BYTES = STEP_W / BYTE_W;

  // Byte offsets of the queued fields
  localparam logic [7:0] OFS_PAT_ADDR = 8'h80;
  localparam logic [7:0] OFS_SRC_ADDR = 8'h84;
  localparam logic [7:0] OFS_DST_ADDR = 8'hA0;
  localparam logic [7:0] OFS_PAT_STEP = 8'h88;
  localparam logic [7:0] OFS_SRC_STEP = 8'h8A;
  localparam logic [7:0] OFS_DST_STEP = 8'h8C;
  localparam logic [7:0] OFS_COUNT_X  = 8'h98;
  localparam logic [7:0] OFS_COUNT_Y  = 8'h9A;
  localparam logic [7:0] OFS_PAT_WRAP = 8'h90;
  localparam logic [7:0] OFS_SRC_WRAP = 8'h91;
  localparam logic [7:0] OFS_ROUTING  = 8'h92;
  localparam logic [7:0] OFS_ROP_FORE = 8'h94;
  localparam logic [7:0] OFS_ROP_BACK = 8'h95;
  localparam logic [7:0] OFS_LAUNCH   = OFS_DST_ADDR + 8'(ADDR_BYTES - 1);

  localparam logic [7:0] WRAP_KEEP      = 8'h77;
  localparam logic [7:0] HOST_DATA_MASK = 8'h37;

  typedef struct packed {
    logic [ADDR_W-1:0] patAddr;
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
    logic [STEP_W-1:0] patStep;
    logic [STEP_W-1:0] srcStep;
    logic [STEP_W-1:0] dstStep;
    logic [STEP_W-1:0] countX;
    logic [STEP_W-1:0] countY;
    logic [BYTE_W-1:0] patWrap;
    logic [BYTE_W-1:0] srcWrap;
    logic [BYTE_W-1:0] routing;
    logic [BYTE_W-1:0] ropFore;
    logic [BYTE_W-1:0] ropBack;
  } blitParamsT;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrQueued;  // accepted byte write to a mapped offset
    logic commit;    // copy queued set (with this cycle's write) to working set
  } ctrlStrobeT;

  function automatic logic inSpan(logic [7:0] off, logic [7:0] base, int bytes);
    return (off >= base) && (off < 8'(base + 8'(bytes)));
  endfunction

  function automatic logic isMapped(logic [7:0] off);
    return inSpan(off, OFS_PAT_ADDR, ADDR_BYTES) || inSpan(off, OFS_SRC_ADDR, ADDR_BYTES) ||
           inSpan(off, OFS_DST_ADDR, ADDR_BYTES) || inSpan(off, OFS_PAT_STEP, STEP_BYTES) ||
           inSpan(off, OFS_SRC_STEP, STEP_BYTES) || inSpan(off, OFS_DST_STEP, STEP_BYTES) ||
           inSpan(off, OFS_COUNT_X, STEP_BYTES)  || inSpan(off, OFS_COUNT_Y, STEP_BYTES)  ||
           (off == OFS_PAT_WRAP) || (off == OFS_SRC_WRAP) || (off == OFS_ROUTING) ||
           (off == OFS_ROP_FORE) || (off == OFS_ROP_BACK);
  endfunction

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrOffset,
  input  logic       engineBusy,
  input  logic [7:0] nextRouting,
  output ctrlStrobeT strobe,
  output logic       startPulse,
  output logic       runNow
);

  logic launchReq;
  logic pending;
  logic commitNow;

  assign launchReq = wrEn && (wrOffset == OFS_LAUNCH);
  assign commitNow = !engineBusy && (pending || launchReq);

  always_comb begin
    strobe.wrQueued = wrEn && isMapped(wrOffset);
    strobe.commit   = commitNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      startPulse <= 1'b0;
      runNow     <= 1'b0;
    end else begin
      startPulse <= commitNow;
      if (commitNow) begin
        pending <= 1'b0;
        runNow  <= ((nextRouting & HOST_DATA_MASK) == 8'h00);
      end else if (launchReq) begin
        pending <= 1'b1;
      end
    end
  end

  // R10: a held launch stays held while the engine is busy
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && engineBusy) |=> pending);

  // R10: no start follows an edge at which the engine was busy
  a_r10_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> !$past(engineBusy));

  // R9: the run flag only moves with a launch
  a_r9_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !startPulse |-> (runNow == $past(runNow)));

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrlStrobeT strobe,
  input  logic [7:0] wrOffset,
  input  logic [7:0] wrData,
  input  logic [7:0] rdOffset,
  output logic [7:0] rdData,
  output logic [7:0] nextRouting,
  output blitParamsT workSet
);

  blitParamsT queued;
  blitParamsT queuedNext;

  function automatic logic [ADDR_W-1:0] put32(logic [ADDR_W-1:0] f, logic [7:0] off,
                                              logic [7:0] base, logic [7:0] d);
    logic [ADDR_W-1:0] r;
    r = f;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (off == 8'(base + 8'(i))) r[BYTE_W*i +: BYTE_W] = d;
    return r;
  endfunction

  function automatic logic [STEP_W-1:0] put16(logic [STEP_W-1:0] f, logic [7:0] off,
                                              logic [7:0] base, logic [7:0] d);
    logic [STEP_W-1:0] r;
    r = f;
    for (int i = 0; i < STEP_BYTES; i++)
      if (off == 8'(base + 8'(i))) r[BYTE_W*i +: BYTE_W] = d;
    return r;
  endfunction

  function automatic logic [7:0] get32(logic [ADDR_W-1:0] f, logic [7:0] off, logic [7:0] base);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (off == 8'(base + 8'(i))) r = f[BYTE_W*i +: BYTE_W];
    return r;
  endfunction

  function automatic logic [7:0] get16(logic [STEP_W-1:0] f, logic [7:0] off, logic [7:0] base);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < STEP_BYTES; i++)
      if (off == 8'(base + 8'(i))) r = f[BYTE_W*i +: BYTE_W];
    return r;
  endfunction

  // Queued set with this cycle's byte merged in
  always_comb begin
    queuedNext = queued;
    if (strobe.wrQueued) begin
      queuedNext.patAddr = put32(queued.patAddr, wrOffset, OFS_PAT_ADDR, wrData);
      queuedNext.srcAddr = put32(queued.srcAddr, wrOffset, OFS_SRC_ADDR, wrData);
      queuedNext.dstAddr = put32(queued.dstAddr, wrOffset, OFS_DST_ADDR, wrData);
      queuedNext.patStep = put16(queued.patStep, wrOffset, OFS_PAT_STEP, wrData);
      queuedNext.srcStep = put16(queued.srcStep, wrOffset, OFS_SRC_STEP, wrData);
      queuedNext.dstStep = put16(queued.dstStep, wrOffset, OFS_DST_STEP, wrData);
      queuedNext.countX  = put16(queued.countX,  wrOffset, OFS_COUNT_X,  wrData);
      queuedNext.countY  = put16(queued.countY,  wrOffset, OFS_COUNT_Y,  wrData);
      if (wrOffset == OFS_PAT_WRAP) queuedNext.patWrap = wrData & WRAP_KEEP;
      if (wrOffset == OFS_SRC_WRAP) queuedNext.srcWrap = wrData & WRAP_KEEP;
      if (wrOffset == OFS_ROUTING)  queuedNext.routing = wrData;
      if (wrOffset == OFS_ROP_FORE) queuedNext.ropFore = wrData;
      if (wrOffset == OFS_ROP_BACK) queuedNext.ropBack = wrData;
    end
  end

  assign nextRouting = queuedNext.routing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      queued  <= '0;
      workSet <= '0;
    end else begin
      queued <= queuedNext;
      if (strobe.commit) workSet <= queuedNext;
    end
  end

  // Combinational readback of the queued set
  always_comb begin
    rdData = get32(queued.patAddr, rdOffset, OFS_PAT_ADDR)
           | get32(queued.srcAddr, rdOffset, OFS_SRC_ADDR)
           | get32(queued.dstAddr, rdOffset, OFS_DST_ADDR)
           | get16(queued.patStep, rdOffset, OFS_PAT_STEP)
           | get16(queued.srcStep, rdOffset, OFS_SRC_STEP)
           | get16(queued.dstStep, rdOffset, OFS_DST_STEP)
           | get16(queued.countX,  rdOffset, OFS_COUNT_X)
           | get16(queued.countY,  rdOffset, OFS_COUNT_Y);
    if (rdOffset == OFS_PAT_WRAP) rdData = queued.patWrap;
    if (rdOffset == OFS_SRC_WRAP) rdData = queued.srcWrap;
    if (rdOffset == OFS_ROUTING)  rdData = queued.routing;
    if (rdOffset == OFS_ROP_FORE) rdData = queued.ropFore;
    if (rdOffset == OFS_ROP_BACK) rdData = queued.ropBack;
  end

  // R6: the working set moves only on a commit
  a_r6_work_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> (workSet == $past(workSet)));

  // R4: masked wrap bits never hold a one
  a_r4_wrap_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((queued.patWrap | queued.srcWrap) & ~WRAP_KEEP) == 8'h00);

endmodule

// File: rtl/blit_reg_queue.sv
module blit_reg_queue
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [7:0]  wrOffset,
  input  logic [7:0]  wrData,
  input  logic [7:0]  rdOffset,
  output logic [7:0]  rdData,
  input  logic        engineBusy,
  output logic        startPulse,
  output logic        runNow,
  output logic [31:0] wkPatAddr,
  output logic [31:0] wkSrcAddr,
  output logic [31:0] wkDstAddr,
  output logic [15:0] wkPatStep,
  output logic [15:0] wkSrcStep,
  output logic [15:0] wkDstStep,
  output logic [15:0] wkCountX,
  output logic [15:0] wkCountY,
  output logic [7:0]  wkPatWrap,
  output logic [7:0]  wkSrcWrap,
  output logic [7:0]  wkRouting,
  output logic [7:0]  wkRopFore,
  output logic [7:0]  wkRopBack
);

  ctrlStrobeT strobe;
  blitParamsT workSet;
  logic [7:0] nextRouting;

  blit_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrOffset(wrOffset),
    .engineBusy(engineBusy), .nextRouting(nextRouting),
    .strobe(strobe), .startPulse(startPulse), .runNow(runNow)
  );

  blit_datapath i_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrOffset(wrOffset), .wrData(wrData),
    .rdOffset(rdOffset), .rdData(rdData), .nextRouting(nextRouting), .workSet(workSet)
  );

  assign wkPatAddr = workSet.patAddr;
  assign wkSrcAddr = workSet.srcAddr;
  assign wkDstAddr = workSet.dstAddr;
  assign wkPatStep = workSet.patStep;
  assign wkSrcStep = workSet.srcStep;
  assign wkDstStep = workSet.dstStep;
  assign wkCountX  = workSet.countX;
  assign wkCountY  = workSet.countY;
  assign wkPatWrap = workSet.patWrap;
  assign wkSrcWrap = workSet.srcWrap;
  assign wkRouting = workSet.routing;
  assign wkRopFore = workSet.ropFore;
  assign wkRopBack = workSet.ropBack;

  // R7: an idle-engine trigger write launches on the next cycle with its byte on top
  a_r7_launch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (wrOffset == OFS_LAUNCH) && !engineBusy) |=>
      (startPulse && (wkDstAddr[31:24] == $past(wrData))));

  // R9: run flag agrees with the routing byte that was launched
  a_r9_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> (runNow == ((wkRouting & HOST_DATA_MASK) == 8'h00)));

endmodule

// File: tb/test_blit_reg_queue.sv
module test_blit_reg_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrOffset = 8'h00;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdOffset = 8'h00;
  logic [7:0]  rdData;
  logic        engineBusy = 1'b0;
  logic        startPulse, runNow;
  logic [31:0] wkPatAddr, wkSrcAddr, wkDstAddr;
  logic [15:0] wkPatStep, wkSrcStep, wkDstStep, wkCountX, wkCountY;
  logic [7:0]  wkPatWrap, wkSrcWrap, wkRouting, wkRopFore, wkRopBack;

  int checkCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  blit_reg_queue i_blit_reg_queue (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrOffset(wrOffset), .wrData(wrData),
    .rdOffset(rdOffset), .rdData(rdData), .engineBusy(engineBusy),
    .startPulse(startPulse), .runNow(runNow),
    .wkPatAddr(wkPatAddr), .wkSrcAddr(wkSrcAddr), .wkDstAddr(wkDstAddr),
    .wkPatStep(wkPatStep), .wkSrcStep(wkSrcStep), .wkDstStep(wkDstStep),
    .wkCountX(wkCountX), .wkCountY(wkCountY), .wkPatWrap(wkPatWrap),
    .wkSrcWrap(wkSrcWrap), .wkRouting(wkRouting), .wkRopFore(wkRopFore),
    .wkRopBack(wkRopBack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one byte write at a falling edge; returns at the next falling edge
  task automatic writeByte(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrOffset = off; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readByte(input logic [7:0] off, output logic [7:0] v);
    rdOffset = off;
    #1;
    v = rdData;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 startPulse", {31'd0, startPulse}, 32'd0);
    chk("R1 runNow", {31'd0, runNow}, 32'd0);
    chk("R1 wkDstAddr", wkDstAddr, 32'd0);
    chk("R1 wkCountX", {16'd0, wkCountX}, 32'd0);
    chk("R1 wkRouting", {24'd0, wkRouting}, 32'd0);
    readByte(8'h83, v);
    chk("R1 queued pattern byte", {24'd0, v}, 32'd0);
  endtask

  task automatic t_addresses();
    logic [7:0] v;
    writeByte(8'h80, 8'h11); writeByte(8'h81, 8'h22);
    writeByte(8'h82, 8'h33); writeByte(8'h83, 8'h44);
    writeByte(8'h84, 8'hA1); writeByte(8'h85, 8'hB2);
    writeByte(8'h86, 8'hC3); writeByte(8'h87, 8'hD4);
    readByte(8'h80, v); chk("R2 pattern byte0", {24'd0, v}, 32'h11);
    readByte(8'h83, v); chk("R2 pattern byte3", {24'd0, v}, 32'h44);
    readByte(8'h86, v); chk("R2 source byte2", {24'd0, v}, 32'hC3);
    chk("R6 working pattern untouched", wkPatAddr, 32'd0);
    chk("R6 no start", {31'd0, startPulse}, 32'd0);
  endtask

  task automatic t_steps_counts();
    logic [7:0] v;
    writeByte(8'h88, 8'h40); writeByte(8'h89, 8'h01);
    writeByte(8'h8A, 8'h80); writeByte(8'h8B, 8'h02);
    writeByte(8'h8C, 8'hFF); writeByte(8'h8D, 8'h03);
    writeByte(8'h98, 8'h0F); writeByte(8'h99, 8'h00);
    writeByte(8'h9A, 8'h07); writeByte(8'h9B, 8'h10);
    readByte(8'h89, v); chk("R3 pattern step hi", {24'd0, v}, 32'h01);
    readByte(8'h8C, v); chk("R3 dest step lo", {24'd0, v}, 32'hFF);
    readByte(8'h9B, v); chk("R3 count Y hi", {24'd0, v}, 32'h10);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    writeByte(8'h90, 8'hFF);
    writeByte(8'h91, 8'h8B);
    readByte(8'h90, v); chk("R4 pattern wrap masked", {24'd0, v}, 32'h77);
    readByte(8'h91, v); chk("R4 source wrap masked", {24'd0, v}, 32'h03);
  endtask

  task automatic t_routing_rop();
    logic [7:0] v;
    writeByte(8'h92, 8'h08);
    writeByte(8'h94, 8'hF0);
    writeByte(8'h95, 8'hCC);
    readByte(8'h92, v); chk("R5 routing", {24'd0, v}, 32'h08);
    readByte(8'h94, v); chk("R5 rop fore", {24'd0, v}, 32'hF0);
    readByte(8'h95, v); chk("R5 rop back", {24'd0, v}, 32'hCC);
  endtask

  task automatic t_launch();
    writeByte(8'hA0, 8'h01); writeByte(8'hA1, 8'h02); writeByte(8'hA2, 8'h03);
    chk("R6 no start before trigger", {31'd0, startPulse}, 32'd0);
    chk("R6 working dest untouched", wkDstAddr, 32'd0);
    writeByte(8'hA3, 8'h04);
    chk("R7 start", {31'd0, startPulse}, 32'd1);
    chk("R7 dest with top byte", wkDstAddr, 32'h04030201);
    chk("R7 pattern addr", wkPatAddr, 32'h44332211);
    chk("R7 source addr", wkSrcAddr, 32'hD4C3B2A1);
    chk("R7 count X", {16'd0, wkCountX}, 32'h000F);
    chk("R7 count Y", {16'd0, wkCountY}, 32'h1007);
    chk("R7 dest step", {16'd0, wkDstStep}, 32'h03FF);
    chk("R7 pattern wrap", {24'd0, wkPatWrap}, 32'h77);
    chk("R7 rop back", {24'd0, wkRopBack}, 32'hCC);
    chk("R9 run flag for routing 08", {31'd0, runNow}, 32'd1);
    @(negedge clk);
    chk("R8 start dropped", {31'd0, startPulse}, 32'd0);
    chk("R9 run flag held", {31'd0, runNow}, 32'd1);
  endtask

  task automatic t_run_flag();
    writeByte(8'h92, 8'h04);
    writeByte(8'hA3, 8'h04);
    chk("R9 run flag for routing 04", {31'd0, runNow}, 32'd0);
    writeByte(8'h92, 8'hC8);
    chk("R9 flag held across queued write", {31'd0, runNow}, 32'd0);
    writeByte(8'hA3, 8'h04);
    chk("R9 run flag for routing C8", {31'd0, runNow}, 32'd1);
  endtask

  task automatic t_deferred();
    writeByte(8'h92, 8'h01);
    @(negedge clk);
    engineBusy = 1'b1;
    writeByte(8'hA3, 8'h05);
    chk("R10 no start while busy", {31'd0, startPulse}, 32'd0);
    chk("R10 working routing kept", {24'd0, wkRouting}, 32'hC8);
    writeByte(8'h98, 8'h7F);
    repeat (3) @(negedge clk);
    chk("R10 still held", {31'd0, startPulse}, 32'd0);
    engineBusy = 1'b0;
    @(negedge clk);
    chk("R10 deferred start", {31'd0, startPulse}, 32'd1);
    chk("R10 later write copied", {16'd0, wkCountX}, 32'h007F);
    chk("R10 dest top byte", wkDstAddr, 32'h05030201);
    chk("R9 run flag for routing 01", {31'd0, runNow}, 32'd0);
    @(negedge clk);
    chk("R8 deferred start single", {31'd0, startPulse}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    writeByte(8'h00, 8'hAA);
    writeByte(8'h93, 8'h55);
    writeByte(8'hFF, 8'h5A);
    readByte(8'h00, v); chk("R11 unmapped read 00", {24'd0, v}, 32'h00);
    readByte(8'h93, v); chk("R11 unmapped read 93", {24'd0, v}, 32'h00);
    readByte(8'h92, v); chk("R11 neighbour routing kept", {24'd0, v}, 32'h01);
    readByte(8'h95, v); chk("R11 neighbour rop kept", {24'd0, v}, 32'hCC);
    chk("R11 no start", {31'd0, startPulse}, 32'd0);
  endtask

  task automatic t_readback_comb();
    logic [7:0] v;
    // offsets changed between edges, no clock in between
    readByte(8'h84, v); chk("R12 source byte0", {24'd0, v}, 32'hA1);
    readByte(8'h87, v); chk("R12 source byte3", {24'd0, v}, 32'hD4);
    readByte(8'h8A, v); chk("R12 source step lo", {24'd0, v}, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addresses();
    t_steps_counts();
    t_wrap();
    t_routing_rop();
    t_launch();
    t_run_flag();
    t_deferred();
    t_unmapped();
    t_readback_comb();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: requirement all, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule